// File: doc/BRIEF.md
# Paced Single-Channel DMA Mover

This block is one channel of a memory-to-memory and memory-to-peripheral mover. Software programs four 32-bit registers: a source address, a destination address, a cycle count and a control word. It then sets the enable bit. The channel then repeats one unit of work, called a cycle, until the count reaches zero. A cycle is one read/write beat in single mode, or four beats in burst mode. Each beat reads one item through a valid/ready read master and writes it through a valid/ready write master.

Each side is configured on its own. It has a bus-select flag for the memory or the peripheral bus, and a 3-bit address step code that is applied after every beat. It also has a 4-bit request-line number. When that number is nonzero, the side is paced: the cycle waits for the request input of that line, and the grant of that line pulses when the cycle ends. Completion sets a finish status flag and a bus error sets an error status flag. Each flag can be routed to a level interrupt through its own enable bit.

The sequencer has six states. IDLE goes to WAIT_REQ on enable with a nonzero count. IDLE stays in IDLE and signals finish when it sees enable with a zero count. WAIT_REQ goes to IDLE when enable is clear, and to RD_ADDR once every paced side has its request. RD_ADDR goes to RD_DATA on read ready. RD_DATA goes to WRITE on a clean response, or to IDLE on a read error. WRITE goes to IDLE on a write error. Otherwise WRITE goes to CYCLE_END after the last beat of the cycle, to IDLE when enable has been cleared, and to RD_ADDR for the next burst beat. CYCLE_END goes to IDLE when the count is spent, with finish, or when enable is clear. Otherwise CYCLE_END goes to WAIT_REQ.

Top module: `hsdma_channel`

## Requirements
- R1: After reset all four registers read zero, irq is low, and neither rd_valid nor wr_valid is asserted.
- R2: Word index 0 reads source address, 1 destination address, 2 cycle count (24 bits, upper bits read zero), 3 control. Control bits 31:28, 23:22, 15 and 11 read zero.
- R3: Control bit0 (enable) starts the channel. Each cycle decrements the count by one. When it reaches zero, finish status (bit1) is set and enable clears itself. Each beat writes exactly the data its read returned.
- R4: The source step code is bits 10:8 and the destination step code is bits 14:12. Codes 001/010/011 add 1/2/4 per beat, 101/110/111 subtract 1/2/4 per beat, and 000 and 100 leave the address unchanged.
- R5: Burst mode (bit3) makes a cycle four beats, so an address advances by four times its step per cycle.
- R6: Bit6 drives rd_mem_sel and bit7 drives wr_mem_sel, where 1 means memory bus and 0 means peripheral bus.
- R7: Bits 21:20 give the item size on rd_size/wr_size: 00 word, 01 half-word, 10 byte. Code 11 is issued as 00.
- R8: A nonzero line number (destination bits 19:16, source bits 27:24) blocks each cycle until req_in of that line is high. The grant_out bit of that line pulses for one clock after the cycle's last write. Line 0 never waits and never grants.
- R9: A read or write error response sets error status (bit4) and clears enable. No further bus request is issued, finish is not set, the count is kept, and the addresses are not stepped by the failed beat.
- R10: A status flag is cleared by writing control with that bit 0. Writing 1 keeps its current value and never sets it.
- R11: irq is high while (finish and bit2) or (error and bit5), and stays high until the status flag is cleared.
- R12: Writing enable=0 during a transfer stops it after the current beat. Finish is not set, and the count keeps only the completed cycles subtracted.
- R13: Enabling with a count of zero sets finish and clears enable without any bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index (byte offset bits 3:2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read address (current source) |
| rd_mem_sel | output | 1 | Read side bus select, 1 = memory |
| rd_size | output | 2 | Read item size code |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | DATA_W | Read response data |
| rd_rerr | input | 1 | Read response error |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write address (current destination) |
| wr_mem_sel | output | 1 | Write side bus select, 1 = memory |
| wr_size | output | 2 | Write item size code |
| wr_data | output | DATA_W | Write data |
| wr_err | input | 1 | Write error, sampled with wr_ready |
| req_in | input | 16 | Pacing request lines |
| grant_out | output | 16 | Pacing grant pulses |
| irq | output | 1 | Level interrupt |

## Verification
The checker watches properties on every clock. Read and write requests hold their address and data while stalled and are never raised together. A grant is a single-clock pulse and line 0 never grants. Finish never rises with enable still set. An error rise leaves both buses idle, and a raised irq persists until software writes control. The bench scenarios cover what needs a whole transfer to show: the final addresses for every step code, burst and width, and the data fidelity of each beat. They also cover the hold-off while a request is low, the exact grant count, the count after an abort and the error paths.

// File: rtl/hsdma_pkg.sv
package hsdma_pkg;
    localparam int REG_W  = 32;
    localparam int LINE_W = 4;

    // writable control bits; status bits are clear-only
    localparam logic [REG_W-1:0] CTRL_WMASK = 32'h0F3F_77FF;
    localparam logic [REG_W-1:0] STS_MASK   = 32'h0000_0012;

    localparam int CB_EN = 0, CB_FIN = 1, CB_ERR = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT_REQ, S_RD_ADDR, S_RD_DATA, S_WRITE, S_CYCLE_END
    } hsdma_state_e;

    typedef struct packed {
        logic [LINE_W-1:0] src_line;
        logic [1:0]        width;
        logic [LINE_W-1:0] dst_line;
        logic [2:0]        dst_step;
        logic [2:0]        src_step;
        logic              dst_mem;
        logic              src_mem;
        logic              err_ie;
        logic              err;
        logic              burst;
        logic              fin_ie;
        logic              fin;
        logic              en;
    } hsdma_cfg_t;
endpackage

// File: rtl/hsdma_addr_step.sv
module hsdma_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        code,
    output logic [ADDR_W-1:0] next
);
    logic [ADDR_W-1:0] mag;

    always_comb begin
        unique case (code[1:0])
            2'b01:   mag = ADDR_W'(1);
            2'b10:   mag = ADDR_W'(2);
            2'b11:   mag = ADDR_W'(4);
            default: mag = '0;
        endcase
        next = code[2] ? addr - mag : addr + mag;
    end
endmodule

// File: rtl/hsdma_regs.sv
module hsdma_regs
    import hsdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [1:0]        sw_idx,
    input  logic [REG_W-1:0]  sw_wdata,
    output logic [REG_W-1:0]  sw_rdata,
    input  logic              hw_step,
    input  logic [ADDR_W-1:0] src_next,
    input  logic [ADDR_W-1:0] dst_next,
    input  logic              hw_cnt_dec,
    input  logic              hw_set_fin,
    input  logic              hw_set_err,
    input  logic              hw_clr_en,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output hsdma_cfg_t        cfg
);
    logic [REG_W-1:0] ctrl_q, ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (sw_we && sw_idx == 2'd3)
            ctrl_d = (sw_wdata & CTRL_WMASK & ~STS_MASK) | (ctrl_q & sw_wdata & STS_MASK);
        if (hw_set_fin) ctrl_d[CB_FIN] = 1'b1;
        if (hw_set_err) ctrl_d[CB_ERR] = 1'b1;
        if (hw_clr_en)  ctrl_d[CB_EN]  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            src_addr <= '0;
            dst_addr <= '0;
            count    <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (sw_we && sw_idx == 2'd0)  src_addr <= sw_wdata[ADDR_W-1:0];
            else if (hw_step)             src_addr <= src_next;
            if (sw_we && sw_idx == 2'd1)  dst_addr <= sw_wdata[ADDR_W-1:0];
            else if (hw_step)             dst_addr <= dst_next;
            if (sw_we && sw_idx == 2'd2)  count <= sw_wdata[CNT_W-1:0];
            else if (hw_cnt_dec)          count <= count - 1'b1;
        end
    end

    always_comb begin
        sw_rdata = '0;
        unique case (sw_idx)
            2'd0: sw_rdata[ADDR_W-1:0] = src_addr;
            2'd1: sw_rdata[ADDR_W-1:0] = dst_addr;
            2'd2: sw_rdata[CNT_W-1:0]  = count;
            default: sw_rdata = ctrl_q;
        endcase
    end

    always_comb begin
        cfg.en       = ctrl_q[0];
        cfg.fin      = ctrl_q[1];
        cfg.fin_ie   = ctrl_q[2];
        cfg.burst    = ctrl_q[3];
        cfg.err      = ctrl_q[4];
        cfg.err_ie   = ctrl_q[5];
        cfg.src_mem  = ctrl_q[6];
        cfg.dst_mem  = ctrl_q[7];
        cfg.src_step = ctrl_q[10:8];
        cfg.dst_step = ctrl_q[14:12];
        cfg.dst_line = ctrl_q[19:16];
        cfg.width    = ctrl_q[21:20];
        cfg.src_line = ctrl_q[27:24];
    end
endmodule

// File: rtl/hsdma_fsm.sv
module hsdma_fsm
    import hsdma_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   burst,
    input  logic [LINE_W-1:0]      src_line,
    input  logic [LINE_W-1:0]      dst_line,
    input  logic                   cnt_is_zero,
    input  logic                   cnt_is_one,
    input  logic [(1<<LINE_W)-1:0] req_in,
    input  logic                   rd_ready,
    input  logic                   rd_rvalid,
    input  logic                   rd_rerr,
    input  logic [DATA_W-1:0]      rd_rdata,
    input  logic                   wr_ready,
    input  logic                   wr_err,
    output logic                   rd_valid,
    output logic                   wr_valid,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   hw_step,
    output logic                   hw_cnt_dec,
    output logic                   hw_set_fin,
    output logic                   hw_set_err,
    output logic                   hw_clr_en,
    output logic [(1<<LINE_W)-1:0] grant
);
    localparam int NLINES = 1 << LINE_W;
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    hsdma_state_e      state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              last_beat, req_ok;

    assign last_beat = !burst || (beat_q == BEAT_W'(BURST_BEATS - 1));
    assign req_ok    = (src_line == '0 || req_in[src_line]) &&
                       (dst_line == '0 || req_in[dst_line]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            wr_data <= '0;
        end else begin
            if (state_q == S_WAIT_REQ)
                beat_q <= '0;
            else if (state_q == S_WRITE && wr_ready && !wr_err && !last_beat)
                beat_q <= beat_q + 1'b1;
            if (state_q == S_RD_DATA && rd_rvalid)
                wr_data <= rd_rdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (en && !cnt_is_zero) state_d = S_WAIT_REQ;
            S_WAIT_REQ:  if (!en) state_d = S_IDLE;
                         else if (req_ok) state_d = S_RD_ADDR;
            S_RD_ADDR:   if (rd_ready) state_d = S_RD_DATA;
            S_RD_DATA:   if (rd_rvalid) state_d = rd_rerr ? S_IDLE : S_WRITE;
            S_WRITE:     if (wr_ready) begin
                             if (wr_err)         state_d = S_IDLE;
                             else if (last_beat) state_d = S_CYCLE_END;
                             else if (!en)       state_d = S_IDLE;
                             else                state_d = S_RD_ADDR;
                         end
            S_CYCLE_END: if (cnt_is_one || !en) state_d = S_IDLE;
                         else state_d = S_WAIT_REQ;
            default:     state_d = S_IDLE;
        endcase
    end

    always_comb begin
        rd_valid   = 1'b0;
        wr_valid   = 1'b0;
        hw_step    = 1'b0;
        hw_cnt_dec = 1'b0;
        hw_set_fin = 1'b0;
        hw_set_err = 1'b0;
        hw_clr_en  = 1'b0;
        grant      = '0;
        unique case (state_q)
            S_IDLE: if (en && cnt_is_zero) begin
                hw_set_fin = 1'b1;
                hw_clr_en  = 1'b1;
            end
            S_RD_ADDR: rd_valid = 1'b1;
            S_RD_DATA: if (rd_rvalid && rd_rerr) begin
                hw_set_err = 1'b1;
                hw_clr_en  = 1'b1;
            end
            S_WRITE: begin
                wr_valid = 1'b1;
                if (wr_ready && wr_err) begin
                    hw_set_err = 1'b1;
                    hw_clr_en  = 1'b1;
                end else if (wr_ready) begin
                    hw_step = 1'b1;
                end
            end
            S_CYCLE_END: begin
                hw_cnt_dec = 1'b1;
                if (cnt_is_one) begin
                    hw_set_fin = 1'b1;
                    hw_clr_en  = 1'b1;
                end
                for (int l = 1; l < NLINES; l++)
                    grant[l] = (LINE_W'(l) == src_line) || (LINE_W'(l) == dst_line);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hsdma_channel.sv
module hsdma_channel
    import hsdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_mem_sel,
    output logic [1:0]        rd_size,
    input  logic              rd_rvalid,
    input  logic [DATA_W-1:0] rd_rdata,
    input  logic              rd_rerr,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_mem_sel,
    output logic [1:0]        wr_size,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_err,
    input  logic [15:0]       req_in,
    output logic [15:0]       grant_out,
    output logic              irq
);
    hsdma_cfg_t        cfg;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0]  count;
    logic              hw_step, hw_cnt_dec, hw_set_fin, hw_set_err, hw_clr_en;
    logic [ADDR_W-1:0] cur_a  [2];
    logic [ADDR_W-1:0] nxt_a  [2];
    logic [2:0]        code_a [2];
    logic [1:0]        size_code;

    hsdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sw_we(reg_we), .sw_idx(reg_idx), .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
        .hw_step(hw_step), .src_next(nxt_a[0]), .dst_next(nxt_a[1]),
        .hw_cnt_dec(hw_cnt_dec), .hw_set_fin(hw_set_fin),
        .hw_set_err(hw_set_err), .hw_clr_en(hw_clr_en),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(count), .cfg(cfg)
    );

    assign cur_a[0]  = src_addr;
    assign cur_a[1]  = dst_addr;
    assign code_a[0] = cfg.src_step;
    assign code_a[1] = cfg.dst_step;

    for (genvar s = 0; s < 2; s++) begin : g_side
        hsdma_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .addr(cur_a[s]), .code(code_a[s]), .next(nxt_a[s])
        );
    end

    hsdma_fsm #(.DATA_W(DATA_W), .BURST_BEATS(BURST_BEATS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(cfg.en), .burst(cfg.burst),
        .src_line(cfg.src_line), .dst_line(cfg.dst_line),
        .cnt_is_zero(count == '0), .cnt_is_one(count == CNT_W'(1)),
        .req_in(req_in),
        .rd_ready(rd_ready), .rd_rvalid(rd_rvalid), .rd_rerr(rd_rerr), .rd_rdata(rd_rdata),
        .wr_ready(wr_ready), .wr_err(wr_err),
        .rd_valid(rd_valid), .wr_valid(wr_valid), .wr_data(wr_data),
        .hw_step(hw_step), .hw_cnt_dec(hw_cnt_dec), .hw_set_fin(hw_set_fin),
        .hw_set_err(hw_set_err), .hw_clr_en(hw_clr_en), .grant(grant_out)
    );

    assign size_code  = (cfg.width == 2'b11) ? 2'b00 : cfg.width;
    assign rd_size    = size_code;
    assign wr_size    = size_code;
    assign rd_addr    = src_addr;
    assign wr_addr    = dst_addr;
    assign rd_mem_sel = cfg.src_mem;
    assign wr_mem_sel = cfg.dst_mem;
    assign irq        = (cfg.fin & cfg.fin_ie) | (cfg.err & cfg.err_ie);
endmodule

// File: rtl/hsdma_channel_chk.sv
module hsdma_channel_chk
    import hsdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_idx,
    input logic              irq,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [15:0]       grant_out,
    input hsdma_cfg_t        cfg
);
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    p_fin_drops_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg.fin) |-> !cfg.en);

    p_grant_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_out != '0 |=> grant_out == '0);

    p_no_grant_line0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_out[0]);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg.err) |-> !rd_valid && !wr_valid && !cfg.en);

    p_irq_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(reg_we && reg_idx == 2'd3) |=> irq);
endmodule

bind hsdma_channel hsdma_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .irq(irq),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .grant_out(grant_out), .cfg(cfg)
);

// File: tb/test_hsdma_channel.sv
`timescale 1ns/1ps
module test_hsdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_valid, rd_mem_sel, wr_valid, wr_mem_sel, irq;
    logic        rd_ready = 1'b1, wr_ready = 1'b1;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [1:0]  rd_size, wr_size;
    logic        rd_rvalid = 1'b0, rd_rerr = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_rdata = '0;
    logic [15:0] req_in = '0;
    logic [15:0] grant_out;

    always #4 clk = ~clk;

    hsdma_channel i_hsdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_mem_sel(rd_mem_sel), .rd_size(rd_size), .rd_rvalid(rd_rvalid),
        .rd_rdata(rd_rdata), .rd_rerr(rd_rerr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_mem_sel(wr_mem_sel), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .req_in(req_in), .grant_out(grant_out), .irq(irq)
    );

    int checks = 0, fails = 0;
    int beats = 0, mism = 0, rd_reqs = 0;
    int grants [16];
    logic        pend = 1'b0, inj_rd_err = 1'b0;
    logic [31:0] paddr, last_rd;
    logic [1:0]  last_rsize, last_wsize;
    logic        last_rsel, last_wsel;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic clear_mon();
        beats = 0; mism = 0; rd_reqs = 0;
        for (int l = 0; l < 16; l++) grants[l] = 0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] c;
        bit done = 0;
        for (int n = 0; n < 3000 && !done; n++) begin
            @(negedge clk);
            rd_reg(2'd3, c);
            if (!c[0]) done = 1;
        end
        check(done, {req, " transfer completes"}, {31'd0, !done}, 32'd0);
    endtask

    // bus responder and monitor, all on the falling edge
    initial begin
        for (int l = 0; l < 16; l++) grants[l] = 0;
        forever begin
            @(negedge clk);
            rd_rvalid = 1'b0;
            rd_rerr   = 1'b0;
            if (pend) begin
                rd_rvalid = 1'b1;
                rd_rdata  = paddr ^ 32'h5A5A_0F0F;
                rd_rerr   = inj_rd_err;
                last_rd   = rd_rdata;
                pend      = 1'b0;
            end
            if (rd_valid && rd_ready) begin
                pend = 1'b1; paddr = rd_addr; rd_reqs++;
                last_rsize = rd_size; last_rsel = rd_mem_sel;
            end
            if (wr_valid && wr_ready) begin
                beats++;
                if (wr_data !== last_rd) mism++;
                last_wsize = wr_size; last_wsel = wr_mem_sel;
            end
            for (int l = 0; l < 16; l++) grants[l] += int'(grant_out[l]);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R3 actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    typedef struct packed {
        logic [31:0] ctrl, src, dst, cnt, esrc, edst, ebeats;
        logic [1:0]  esize;
        logic        rsel, wsel;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_33C5, 32'h1000, 32'h2000, 32'd3, 32'h100C, 32'h200C, 32'd3, 2'd0, 1'b1, 1'b1},
        '{32'h0000_7309, 32'h0100, 32'h0400, 32'd2, 32'h0120, 32'h03E0, 32'd8, 2'd0, 1'b0, 1'b0},
        '{32'h0020_0141, 32'h0050, 32'h0080, 32'd5, 32'h0055, 32'h0080, 32'd5, 2'd2, 1'b1, 1'b0},
        '{32'h0010_2681, 32'h0200, 32'h0300, 32'd4, 32'h01F8, 32'h0308, 32'd4, 2'd1, 1'b0, 1'b1},
        '{32'h0000_5409, 32'h0010, 32'h0020, 32'd1, 32'h0010, 32'h001C, 32'd4, 2'd0, 1'b0, 1'b0},
        '{32'h0030_0201, 32'h0000, 32'h0044, 32'd1, 32'h0002, 32'h0044, 32'd1, 2'd0, 1'b0, 1'b0}
    };

    initial begin
        logic [31:0] v;
        int          b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rd_reg(2'(i), v);
            check(v == 0, "R1 register reset", v, 0);
        end
        check(!irq && !rd_valid && !wr_valid, "R1 outputs idle", {irq, rd_valid, wr_valid}, 0);

        // R2 readback and masks; R10 write-1 does not set status
        wr_reg(2'd0, 32'hDEAD_BEEF);
        rd_reg(2'd0, v); check(v == 32'hDEAD_BEEF, "R2 source readback", v, 32'hDEAD_BEEF);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_reg(2'd2, v); check(v == 32'h00FF_FFFF, "R2 count is 24 bits", v, 32'h00FF_FFFF);
        wr_reg(2'd3, 32'hFFFF_FFFE);
        rd_reg(2'd3, v); check(v == 32'h0F3F_77EC, "R2 R10 control mask, status not set", v, 32'h0F3F_77EC);
        wr_reg(2'd3, 32'h0);

        // table of transfers: R3 R4 R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            clear_mon();
            wr_reg(2'd0, VECS[i].src);
            wr_reg(2'd1, VECS[i].dst);
            wr_reg(2'd2, VECS[i].cnt);
            wr_reg(2'd3, VECS[i].ctrl);
            wait_done("R3");
            @(negedge clk);
            check(beats == int'(VECS[i].ebeats), "R3 R5 beat count", beats, VECS[i].ebeats);
            check(mism == 0, "R3 data fidelity", mism, 0);
            rd_reg(2'd0, v); check(v == VECS[i].esrc, "R4 R5 final source", v, VECS[i].esrc);
            rd_reg(2'd1, v); check(v == VECS[i].edst, "R4 R5 final destination", v, VECS[i].edst);
            rd_reg(2'd2, v); check(v == 0, "R3 count spent", v, 0);
            rd_reg(2'd3, v);
            check(v == ((VECS[i].ctrl & ~32'h1) | 32'h2), "R3 finish set, enable cleared", v,
                  (VECS[i].ctrl & ~32'h1) | 32'h2);
            check(irq == VECS[i].ctrl[2], "R11 irq from finish", irq, VECS[i].ctrl[2]);
            check(last_rsize == VECS[i].esize && last_wsize == VECS[i].esize, "R7 item size",
                  {last_rsize, last_wsize}, {VECS[i].esize, VECS[i].esize});
            check(last_rsel == VECS[i].rsel && last_wsel == VECS[i].wsel, "R6 bus select",
                  {last_rsel, last_wsel}, {VECS[i].rsel, VECS[i].wsel});
            wr_reg(2'd3, 32'h0);
        end

        // R13 zero count; R10 status write semantics; R11 level
        clear_mon();
        wr_reg(2'd2, 32'd0);
        wr_reg(2'd3, 32'h5);
        repeat (3) @(negedge clk);
        rd_reg(2'd3, v); check(v == 32'h6, "R13 zero count finishes", v, 32'h6);
        check(rd_reqs == 0, "R13 no bus activity", rd_reqs, 0);
        check(irq, "R11 irq level", irq, 1);
        wr_reg(2'd3, 32'h6);
        rd_reg(2'd3, v); check(v == 32'h6 && irq, "R10 write 1 keeps status", v, 32'h6);
        wr_reg(2'd3, 32'h4);
        rd_reg(2'd3, v); check(v == 32'h4 && !irq, "R10 R11 write 0 clears status", {v[30:0], irq}, 32'h8);
        wr_reg(2'd3, 32'h0);

        // R9 read error
        clear_mon();
        inj_rd_err = 1'b1;
        wr_reg(2'd0, 32'h100); wr_reg(2'd1, 32'h200); wr_reg(2'd2, 32'd3);
        wr_reg(2'd3, 32'h3321);
        wait_done("R9");
        repeat (5) @(negedge clk);
        inj_rd_err = 1'b0;
        rd_reg(2'd3, v); check(v == 32'h3330, "R9 read error status", v, 32'h3330);
        check(irq, "R9 R11 error irq", irq, 1);
        check(beats == 0 && rd_reqs == 1, "R9 no further requests", {beats[15:0], rd_reqs[15:0]}, 32'h1);
        rd_reg(2'd2, v); check(v == 3, "R9 count kept", v, 3);
        wr_reg(2'd3, 32'h0);

        // R9 write error
        clear_mon();
        wr_err = 1'b1;
        wr_reg(2'd3, 32'h3321);
        wait_done("R9");
        repeat (5) @(negedge clk);
        wr_err = 1'b0;
        check(beats == 1 && rd_reqs == 1, "R9 write error stops", {beats[15:0], rd_reqs[15:0]}, 32'h10001);
        rd_reg(2'd0, v); check(v == 32'h100, "R9 no step on failed beat", v, 32'h100);
        rd_reg(2'd3, v); check(v[4] && !v[1], "R9 error without finish", v, 32'h10);
        wr_reg(2'd3, 32'h0);

        // R12 abort mid-transfer in burst mode
        clear_mon();
        wr_reg(2'd2, 32'd100);
        wr_reg(2'd3, 32'h3309);
        repeat (23) @(negedge clk);
        wr_reg(2'd3, 32'h3308);
        repeat (10) @(negedge clk);
        b0 = beats;
        repeat (20) @(negedge clk);
        check(beats == b0 && b0 > 0, "R12 stops after beat", beats, b0);
        rd_reg(2'd2, v); check(v == 32'(100 - b0 / 4), "R12 count keeps done cycles", v, 100 - b0 / 4);
        rd_reg(2'd3, v); check(v == 32'h3308, "R12 no finish on abort", v, 32'h3308);
        wr_reg(2'd3, 32'h0);

        // R8 pacing on both sides: src line 5, dst line 3
        clear_mon();
        wr_reg(2'd2, 32'd2);
        wr_reg(2'd3, 32'h0503_3301);
        repeat (15) @(negedge clk);
        check(rd_reqs == 0, "R8 waits for requests", rd_reqs, 0);
        req_in[3] = 1'b1;
        repeat (15) @(negedge clk);
        check(rd_reqs == 0, "R8 waits for both lines", rd_reqs, 0);
        req_in[5] = 1'b1;
        wait_done("R8");
        @(negedge clk);
        check(beats == 2, "R8 paced beats", beats, 2);
        check(grants[3] == 2 && grants[5] == 2, "R8 grant per cycle", {grants[3][15:0], grants[5][15:0]}, 32'h20002);
        check(grants[0] == 0 && grants[1] == 0, "R8 no stray grants", grants[0] + grants[1], 0);
        req_in = '0;
        wr_reg(2'd3, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule